// File: doc/BRIEF.md
# Carry-Save First-Order Allpass Wave Digital Filter Section

This block is a bit-parallel first-order allpass section built around a symmetric two-port adaptor. Its coefficient is fixed at -0.75. One section input sample may enter per clock, marked by a valid strobe. The adaptor's second port is fed by a single delay register that closes the recursive loop. The other output port gives the section output. Sections of this kind are the recursive core of halfband polyphase interpolators and decimators. In that use the loop period sets the highest sample rate the filter can reach.

The delayed state is held redundantly, as a sum vector and a carry vector. It is never merged inside the loop. The adaptor is evaluated in its rearranged form, with B1 = (1+a)A2 - a*A1 and B2 = (1-a)A1 + a*A2. This lets the negated state, the quarter-scaled state and one precomputed input term fall together into a single tree of 3:2 carry-save adders. The tree is three adder levels deep. Three things sit outside the loop: the input-side terms, the final carry-propagate merge and the output register.

The quantised product is defined as floor((A2 - A1)/4). A small rounding correction is built from the two low bits of each operand, so the quantisation matches bit for bit what a direct evaluation of the original adaptor form gives. Before the state vectors are stored, a sign-repair step runs on their top two bits. After it, their signed sum equals the true state, so arithmetic right shifts of each vector stay exact.

Top module: `wdf_allpass_cs`

## Requirements
- R1: While `rst` is high at a rising edge, the stored state (sum plus carry) becomes zero, `out_valid` becomes 0 and `y_out` becomes 0. Input samples presented during reset are discarded.
- R2: For an accepted sample x with stored state s, the next `y_out` is x + floor((s - x)/4) as a signed two's-complement value. Flooring rounds toward minus infinity, so from a zero state x = 1 gives 0.
- R3: For an accepted sample, the stored state becomes 2x - s + floor((s - x)/4), which is the B2 port of the original adaptor form. Each later output depends on it through R2.
- R4: `out_valid` equals `in_valid` delayed by exactly one clock. `y_out` carries the result of the sample accepted at the previous edge.
- R5: When `in_valid` is low, neither the stored state nor `y_out` changes.
- R6: The signed sum of the two stored state vectors equals the true state value. It stays within plus or minus 2^(W+HEAD-2) for every input sequence, including full-scale inputs that alternate each sample.
- R7: If a constant input is held long enough, the output settles to exactly that input value.
- R8: `y_out` is W+HEAD bits wide and never wraps. Outputs whose magnitude exceeds the W-bit input range are delivered exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `x_in` as a sample to be processed this cycle |
| x_in | input | W | Section input sample, signed two's complement |
| out_valid | output | 1 | Marks `y_out` as a fresh result |
| y_out | output | W+HEAD | Section output, signed two's complement, registered |

## Verification
The bench uses the defaults: W = 16 and HEAD = 4, which gives a 20-bit internal word and a sign-repair bound of plus or minus 2^18. Full-scale inputs that alternate sign, and steps between negative and positive full scale, drive the state to around 7 * 2^15. That is close enough to the bound to exercise the top-bit repair on both polarities. The same step patterns push the output past the 16-bit range, which R8 needs.

Long constant runs test exact settling under floor rounding. Random samples with random valid gaps are compared every clock against a plain integer model of the original adaptor form. The model's state updates only on accepted samples.

// File: rtl/wdf_cs_pkg.sv
package wdf_cs_pkg;

  // Kind of sign repair applied to a carry-save pair before it is stored.
  typedef enum logic [1:0] {
    REPAIR_NONE = 2'd0,
    REPAIR_SET  = 2'd1,
    REPAIR_CLR  = 2'd2
  } repair_e;

  // The true value is known to lie in [-Q, Q), with Q = 2^(N-2).
  // If both vectors sit in the quarter [Q, 2Q) (top bits 01), their signed
  // sum exceeds the true value by 2^N: set both MSBs.
  // If both sit in [-2Q, -Q) (top bits 10), the sum is short by 2^N: clear both.
  function automatic repair_e repair_kind(input logic [1:0] s_top,
                                          input logic [1:0] c_top);
    if (s_top == 2'b01 && c_top == 2'b01) return REPAIR_SET;
    if (s_top == 2'b10 && c_top == 2'b10) return REPAIR_CLR;
    return REPAIR_NONE;
  endfunction

  // Rounding carry of floor((a+b+c+1)/4) that the per-vector shifts drop.
  function automatic logic [1:0] floor_carry(input logic [1:0] a,
                                             input logic [1:0] b,
                                             input logic [1:0] c);
    logic [3:0] t;
    t = {2'b00, a} + {2'b00, b} + {2'b00, c} + 4'd1;
    return t[3:2];
  endfunction

endpackage

// File: rtl/wdf_csa.sv
// One level of 3:2 carry-save adders over an N-bit word, modulo 2^N.
module wdf_csa #(
  parameter int N = 20
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  output logic [N-1:0] s,
  output logic [N-1:0] cy
);
  logic [N-2:0] maj;

  for (genvar i = 0; i < N; i++) begin : g_sum
    assign s[i] = a[i] ^ b[i] ^ c[i];
  end

  // The carry out of the top bit has weight 2^N and is dropped on purpose.
  for (genvar i = 0; i < N - 1; i++) begin : g_maj
    assign maj[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end

  assign cy = {maj, 1'b0};
endmodule

// File: rtl/wdf_input_prep.sv
// Non-recursive input-side terms. These are worked out from the sample alone,
// so their carry-propagate additions never sit in the recursive loop.
module wdf_input_prep #(
  parameter int W = 16,
  parameter int N = 20
) (
  input  logic [W-1:0] x_in,
  output logic [N-1:0] x_term,
  output logic [N-1:0] z_term,
  output logic [1:0]   y_lo
);
  localparam int EXT = N - W;

  logic [N-1:0] a1;
  logic [N-1:0] y_inv;
  logic [N-1:0] y_q;

  assign a1    = {{EXT{x_in[W-1]}}, x_in};
  assign y_inv = ~a1;                                  // equals -x - 1
  assign y_q   = N'($signed(y_inv) >>> 2);             // floor((-x-1)/4)
  assign y_lo  = y_inv[1:0];

  // Loop operand: 2x + floor((-x-1)/4) + 2. The +2 completes the two
  // one's-complement negations of the state vectors.
  assign x_term = (a1 << 1) + y_q + N'(2);

  // Output operand: x + floor((-x-1)/4).
  assign z_term = a1 + y_q;
endmodule

// File: rtl/wdf_loop_tree.sv
// Recursive carry-save tree: from the stored pair (S, C) and the input
// terms it forms the next state pair, plus the quantised-product pair that
// the output branch reuses.
module wdf_loop_tree #(
  parameter int N = 20
) (
  input  logic [N-1:0] st_sum,
  input  logic [N-1:0] st_car,
  input  logic [N-1:0] x_term,
  input  logic [1:0]   y_lo,
  output logic [N-1:0] nxt_s,
  output logic [N-1:0] nxt_c,
  output logic [N-1:0] q_s,
  output logic [N-1:0] q_c
);
  import wdf_cs_pkg::*;

  logic [N-1:0] neg_s, neg_c;
  logic [N-1:0] qtr_s, qtr_c;
  logic [N-1:0] k_vec;
  logic [N-1:0] l1_s, l1_c;
  logic [N-1:0] l2_s, l2_c;

  assign neg_s = ~st_sum;
  assign neg_c = ~st_car;
  assign qtr_s = N'($signed(st_sum) >>> 2);
  assign qtr_c = N'($signed(st_car) >>> 2);
  assign k_vec = N'(floor_carry(st_sum[1:0], st_car[1:0], y_lo));

  // Level 1a: -S - C + input term (the two +1 are inside x_term).
  wdf_csa #(.N(N)) u_l1a (
    .a(neg_s), .b(neg_c), .c(x_term), .s(l1_s), .cy(l1_c)
  );

  // Level 1b: the quantised product floor((S + C - x)/4) without the input
  // share, kept in carry-save form.
  wdf_csa #(.N(N)) u_l1b (
    .a(qtr_s), .b(qtr_c), .c(k_vec), .s(q_s), .cy(q_c)
  );

  // Level 2.
  wdf_csa #(.N(N)) u_l2 (
    .a(l1_s), .b(l1_c), .c(q_s), .s(l2_s), .cy(l2_c)
  );

  // Level 3.
  wdf_csa #(.N(N)) u_l3 (
    .a(l2_s), .b(l2_c), .c(q_c), .s(nxt_s), .cy(nxt_c)
  );
endmodule

// File: rtl/wdf_sign_repair.sv
// Adjusts the MSBs of a carry-save pair so that its signed sum is the
// true value, provided that value lies in [-2^(N-2), 2^(N-2)).
module wdf_sign_repair #(
  parameter int N = 20
) (
  input  logic [N-1:0] s_in,
  input  logic [N-1:0] c_in,
  output logic [N-1:0] s_out,
  output logic [N-1:0] c_out
);
  import wdf_cs_pkg::*;

  repair_e kind;

  assign kind = repair_kind(s_in[N-1:N-2], c_in[N-1:N-2]);

  always_comb begin
    s_out = s_in;
    c_out = c_in;
    case (kind)
      REPAIR_SET: begin
        s_out[N-1] = 1'b1;
        c_out[N-1] = 1'b1;
      end
      REPAIR_CLR: begin
        s_out[N-1] = 1'b0;
        c_out[N-1] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wdf_allpass_cs.sv
module wdf_allpass_cs #(
  parameter int W    = 16,
  parameter int HEAD = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [W-1:0]        x_in,
  output logic                out_valid,
  output logic [W+HEAD-1:0]   y_out
);
  localparam int N = W + HEAD;

  // Recursive state in carry-save form.
  logic [N-1:0] st_sum, st_car;

  // Input-side terms.
  logic [N-1:0] x_term, z_term;
  logic [1:0]   y_lo;

  // Loop tree results.
  logic [N-1:0] raw_s, raw_c;
  logic [N-1:0] q_s, q_c;
  logic [N-1:0] fix_s, fix_c;

  // Output branch.
  logic [N-1:0] o_s, o_c;
  logic [N-1:0] y_next;

  wdf_input_prep #(.W(W), .N(N)) u_prep (
    .x_in   (x_in),
    .x_term (x_term),
    .z_term (z_term),
    .y_lo   (y_lo)
  );

  wdf_loop_tree #(.N(N)) u_tree (
    .st_sum (st_sum),
    .st_car (st_car),
    .x_term (x_term),
    .y_lo   (y_lo),
    .nxt_s  (raw_s),
    .nxt_c  (raw_c),
    .q_s    (q_s),
    .q_c    (q_c)
  );

  wdf_sign_repair #(.N(N)) u_repair (
    .s_in  (raw_s),
    .c_in  (raw_c),
    .s_out (fix_s),
    .c_out (fix_c)
  );

  // Non-recursive output: x + floor((s - x)/4), merged by one carry-propagate add.
  wdf_csa #(.N(N)) u_out_csa (
    .a(z_term), .b(q_s), .c(q_c), .s(o_s), .cy(o_c)
  );

  assign y_next = o_s + o_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_sum    <= '0;
      st_car    <= '0;
      y_out     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        st_sum <= fix_s;
        st_car <= fix_c;
        y_out  <= y_next;
      end
    end
  end
endmodule

// File: rtl/wdf_allpass_cs_chk.sv
module wdf_allpass_cs_chk #(
  parameter int W    = 16,
  parameter int HEAD = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [W-1:0]        x_in,
  input logic                out_valid,
  input logic [W+HEAD-1:0]   y_out,
  input logic [W+HEAD-1:0]   st_sum,
  input logic [W+HEAD-1:0]   st_car
);
  localparam int N = W + HEAD;
  localparam int M = N + 3;
  localparam logic signed [M-1:0] BOUND = M'(1) <<< (N - 2);

  logic signed [M-1:0] st_v, xv, yv, dv, qv, exp_y, exp_s;

  // True state, the sample and the output as wide signed integers.
  assign st_v  = $signed({{3{st_sum[N-1]}}, st_sum}) + $signed({{3{st_car[N-1]}}, st_car});
  assign xv    = $signed({{(M-W){x_in[W-1]}}, x_in});
  assign yv    = $signed({{3{y_out[N-1]}}, y_out});
  // Original adaptor form with the coefficient -0.75.
  assign dv    = st_v - xv;
  assign qv    = dv >>> 2;
  assign exp_y = xv + qv;
  assign exp_s = (xv <<< 1) - st_v + qv;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (st_v == 0 && !out_valid && yv == 0)); // R1

  AST_OUT_VALUE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> yv == $past(exp_y)); // R2

  AST_STATE_STEP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> st_v == $past(exp_s)); // R3

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R4

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(y_out) && st_v == $past(st_v))); // R5

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st_v >= -BOUND && st_v < BOUND)); // R6

endmodule

bind wdf_allpass_cs wdf_allpass_cs_chk #(.W(W), .HEAD(HEAD)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .x_in      (x_in),
  .out_valid (out_valid),
  .y_out     (y_out),
  .st_sum    (st_sum),
  .st_car    (st_car)
);

// File: tb/test_wdf_allpass_cs.sv
module test_wdf_allpass_cs;
  localparam int W    = 16;
  localparam int HEAD = 4;
  localparam int N    = W + HEAD;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] x_in = '0;
  logic         out_valid;
  logic [N-1:0] y_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Behavioural model state.
  int    m_state = 0;
  int    m_y     = 0;
  bit    m_valid = 0;
  string m_tag   = "R1";
  int    max_abs = 0;

  always #10 clk = ~clk;   // 50 MHz

  wdf_allpass_cs #(.W(W), .HEAD(HEAD)) i_wdf_allpass_cs (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
    .out_valid(out_valid), .y_out(y_out)
  );

  function automatic int y_int();
    return int'($signed(y_out));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge: compare outputs against the model.
  task automatic compare();
    check("R4", int'(out_valid), int'(m_valid));
    check(m_tag, y_int(), m_y);
    if (out_valid) begin
      if (y_int() > max_abs) max_abs = y_int();
      if (-y_int() > max_abs) max_abs = -y_int();
    end
  endtask

  // Compare, then present one input cycle and advance the model.
  task automatic drive(input bit v, input int x, input string req);
    int d, q;
    @(negedge clk);
    compare();
    in_valid = v;
    x_in     = W'(x);
    if (v) begin
      d       = m_state - x;
      q       = d >>> 2;            // floor toward minus infinity
      m_y     = x + q;
      m_state = 2 * x - m_state + q;
      m_valid = 1;
      m_tag   = req;
    end else begin
      m_valid = 0;
      m_tag   = "R5";
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; x_in = W'(1234);
    @(negedge clk);
    x_in = W'(-777);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0; x_in = '0;
    m_state = 0; m_y = 0; m_valid = 0; m_tag = "R1";
    // Outputs reflect the reset edges only.
    check("R1", int'(out_valid), 0);
    check("R1", y_int(), 0);
  endtask

  initial begin
    do_reset();

    // Floor rounding from a zero state: x = 1 gives 0.
    drive(1, 1, "R2");
    drive(0, 0, "R2");
    check("R2", y_int(), 0);
    drive(1, -1, "R2");
    drive(1, 5, "R2");
    drive(1, -6, "R2");
    drive(0, 99, "R5");
    drive(0, -99, "R5");
    drive(1, 3, "R2");

    // Random samples with random valid gaps.
    for (int i = 0; i < 2000; i++) begin
      drive(($urandom % 4) != 0, int'($signed(W'($urandom))), "R3");
    end

    // Full-scale alternation stresses the state bound and sign repair.
    for (int i = 0; i < 300; i++) begin
      drive(1, (i % 2 == 0) ? 32767 : -32768, "R6");
    end
    for (int i = 0; i < 40; i++) begin
      drive(1, (i % 3 == 0) ? -32768 : 32767, "R6");
    end

    // Constant runs settle exactly; the steps between them overshoot.
    for (int i = 0; i < 100; i++) drive(1, -32768, "R7");
    drive(0, 0, "R7");
    check("R7", y_int(), -32768);
    for (int i = 0; i < 100; i++) drive(1, 32767, "R8");
    drive(0, 0, "R7");
    check("R7", y_int(), 32767);
    for (int i = 0; i < 100; i++) drive(1, -32768, "R8");
    drive(0, 0, "R7");
    check("R7", y_int(), -32768);
    check("R8", int'(max_abs > 32768), 1);

    // Reset in the middle of activity.
    for (int i = 0; i < 10; i++) drive(1, 20000 - 3000 * i, "R3");
    do_reset();
    drive(1, 8, "R1");
    drive(0, 0, "R1");
    check("R1", y_int(), 8 + ((0 - 8) >>> 2));

    @(negedge clk);
    compare();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule